// File: doc/BRIEF.md
# Multiplierless Shared-Subexpression FIR Filter

This block is a fixed 12-tap linear-phase FIR filter built with no multipliers. Every coefficient is a 12-digit canonic signed digit fraction. The filter is symmetric, so only six distinct values exist, and tap `11-i` carries the same value as tap `i`. A shared network turns each accepted sample into a small set of subexpressions, using only shifts, adders and subtractors:

- three horizontal patterns: 5x, 9x and 7x;
- two five-digit super-patterns: 21x and 19x;
- one vertical pair: the current accepted sample plus the previously accepted one.

The terms each tap needs are shifted sums of these shared values. They feed a transposed chain of registered accumulators, so the filter produces one output per accepted sample.

All arithmetic is integer and works at full precision. Coefficient digit `k` (for k = 1..12) is scaled to the integer weight 2^(12-k). The output is therefore the exact convolution with coefficients multiplied by 4096, with no rounding. The output is `IN_W + 13` bits wide, which covers the sum of the absolute coefficient values, 6524.

Both sides of the block use valid/ready streams:

- An input sample is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low only while a result is being held because the consumer has `out_ready` low.
- A result is presented on `out_data` with `out_valid` from the edge that accepted its sample. It stays stable until it is taken with `out_ready`.
- With `out_ready` held high, the block accepts one sample on every cycle.

The shared network uses 11 adders and subtractors to form the terms: 6 for the subexpressions and 5 to combine them.

Top module: `fir_cse_top`

## Requirements
- R1: A synchronous active-high `rst` clears every accumulator stage and the stored previous sample, drives `out_valid` low and leaves `in_ready` high. After reset, the first valid output depends only on samples accepted after reset.
- R2: The impulse response, as integers, is c0..c11 = 629, 668, 133, 338, 306, 1188, 1188, 306, 338, 133, 668, 629. These values come from the digit rows below, each read from digit 1 to digit 12, where digit k weighs 2^(12-k):
  - h0: 0 0 1 0 1 0 0 -1 0 1 0 1
  - h1: 0 0 1 0 1 0 1 0 0 -1 0 0
  - h2: 0 0 0 0 1 0 0 0 0 1 0 1
  - h3: 0 0 0 1 0 1 0 1 0 0 1 0
  - h4: 0 0 0 1 0 1 0 -1 0 0 1 0
  - h5: 0 1 0 0 1 0 1 0 0 1 0 0
  
  Tap 11-i equals tap i.
- R3: For any sequence of accepted samples x[n], which are two's-complement values of `IN_W` bits, the output is exactly y[n] = sum over k of c_k * x[n-k]. It is a signed value of `IN_W+13` bits with no overflow or rounding, including runs of the most positive and the most negative input.
- R4: The result for the 12th sample accepted since reset is the first one presented with `out_valid` high. The results for accepts 1 to 11 never assert `out_valid`. A result becomes visible on the clock edge that accepts its sample.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low, `out_data` and `out_valid` hold, and any offered `in_valid`/`in_data` is ignored. Ignored samples never enter the filter state.
- R6: Cycles with `in_valid` low change neither the filter state nor the held result. The vertical pair always combines an accepted sample with the sample accepted just before it, however many idle cycles lie between them.
- R7: When a presented result is taken with `out_ready` high and no new sample is accepted on that edge, `out_valid` falls on that edge. With both sides ready, one result is produced per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_data | output | IN_W+13 | Signed full-precision result, coefficients scaled by 4096 |

## Verification
Two effects are hard to reach from the ports, and both land in the first valid result after a mid-stream reset. One is the vertical pair's spill from one stage into the next. The other is a stale value left in the last accumulator stage. Either shows only if the previous sample is kept across stalls and gaps and the chain is truly cleared. The bench therefore mixes stalled offers and idle gaps between accepts, and compares every result with its own convolution model. It also resets in the middle of a nonzero stream and checks the 12th fresh result against a model with an empty history. An impulse placed after eleven zeros brings all twelve coefficients out, one by one, through the accept-gated valid.

// File: rtl/fir_cse_pkg.sv
package fir_cse_pkg;

  // Filter geometry
  localparam int TAPS        = 12;
  localparam int HALF        = TAPS / 2;
  localparam int COEF_DIGITS = 12;
  // Sum of |c_k| scaled by 2^COEF_DIGITS is 6524, which needs 13 extra magnitude bits
  localparam int GAIN_BITS   = 13;

  // Indices into the shared term bus
  localparam int T_P0    = 0;   // 512*pair + 117x
  localparam int T_P1    = 1;   // 128*pair + 28x
  localparam int T_A5    = 2;   // 5x
  localparam int T_P3    = 3;   // 336x + 2*pair
  localparam int T_S19   = 4;   // 304x
  localparam int T_P5    = 5;   // 1188x
  localparam int T_K0    = 6;   // 117x
  localparam int T_C7S   = 7;   // 28x
  localparam int T_S21   = 8;   // 336x
  localparam int T_V1    = 9;   // 2*pair
  localparam int T_V7    = 10;  // 128*pair
  localparam int T_V9    = 11;  // 512*pair
  localparam int T_ZERO  = 12;  // constant zero
  localparam int NUM_TERMS = 13;

  // Main term added at each transposed stage.
  // The mirror half splits off the pair part and places it one stage earlier.
  function automatic int stage_primary(input int stage);
    case (stage)
      0:       return T_P0;
      1:       return T_P1;
      2:       return T_A5;
      3:       return T_P3;
      4:       return T_S19;
      5:       return T_P5;
      6:       return T_P5;
      7:       return T_S19;
      8:       return T_S21;
      9:       return T_A5;
      10:      return T_C7S;
      default: return T_K0;
    endcase
  endfunction

  // Second term per stage: only the mirror stages that take a pair part use one
  function automatic int stage_secondary(input int stage);
    case (stage)
      7:       return T_V1;
      9:       return T_V7;
      10:      return T_V9;
      default: return T_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/cse_subexpr_bank.sv
module cse_subexpr_bank #(
  parameter int W = 29
) (
  input  logic signed [W-1:0] cur,
  input  logic signed [W-1:0] prev,
  output logic signed [W-1:0] sx_a5,
  output logic signed [W-1:0] sx_b9,
  output logic signed [W-1:0] sx_c7,
  output logic signed [W-1:0] sx_s21,
  output logic signed [W-1:0] sx_s19,
  output logic signed [W-1:0] sx_pair
);
  // Six adders/subtractors in total
  always_comb begin
    sx_a5   = (cur <<< 2) + cur;      // digits [1 0 1]
    sx_b9   = (cur <<< 3) + cur;      // digits [1 0 0 1]
    sx_c7   = (cur <<< 3) - cur;      // digits [1 0 0 -1]
    sx_s21  = (sx_a5 <<< 2) + cur;    // [1 0 1] followed by +1
    sx_s19  = (sx_a5 <<< 2) - cur;    // [1 0 1] followed by -1
    sx_pair = cur + prev;             // vertical pair across two accepted samples
  end
endmodule

// File: rtl/cse_product_net.sv
module cse_product_net
  import fir_cse_pkg::*;
#(
  parameter int W = 29
) (
  input  logic signed [W-1:0] sx_a5,
  input  logic signed [W-1:0] sx_b9,
  input  logic signed [W-1:0] sx_c7,
  input  logic signed [W-1:0] sx_s21,
  input  logic signed [W-1:0] sx_s19,
  input  logic signed [W-1:0] sx_pair,
  output logic signed [W-1:0] term [NUM_TERMS]
);
  logic signed [W-1:0] k0, p0, p1, p3, p5;

  // Five combining adders
  always_comb begin
    k0 = (sx_c7 <<< 4) + sx_a5;             // 117x
    p5 = (sx_b9 <<< 7) + (sx_b9 <<< 2);     // 1188x
    p0 = (sx_pair <<< 9) + k0;
    p1 = (sx_pair <<< 7) + (sx_c7 <<< 2);
    p3 = (sx_s21 <<< 4) + (sx_pair <<< 1);
  end

  // Remaining terms are pure shifts of shared values
  always_comb begin
    term[T_P0]   = p0;
    term[T_P1]   = p1;
    term[T_A5]   = sx_a5;
    term[T_P3]   = p3;
    term[T_S19]  = sx_s19 <<< 4;
    term[T_P5]   = p5;
    term[T_K0]   = k0;
    term[T_C7S]  = sx_c7 <<< 2;
    term[T_S21]  = sx_s21 <<< 4;
    term[T_V1]   = sx_pair <<< 1;
    term[T_V7]   = sx_pair <<< 7;
    term[T_V9]   = sx_pair <<< 9;
    term[T_ZERO] = '0;
  end
endmodule

// File: rtl/cse_tap_stage.sv
module cse_tap_stage #(
  parameter int W = 29
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic signed [W-1:0] pri,
  input  logic signed [W-1:0] sec,
  input  logic signed [W-1:0] carry_in,
  output logic signed [W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (adv) begin
      acc_q <= pri + sec + carry_in;
    end
  end
endmodule

// File: rtl/cse_tap_chain.sv
module cse_tap_chain
  import fir_cse_pkg::*;
#(
  parameter int W = 29
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic signed [W-1:0] term [NUM_TERMS],
  output logic signed [W-1:0] y
);
  logic signed [W-1:0] link [TAPS+1];

  assign link[TAPS] = '0;

  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    localparam int PI = stage_primary(k);
    localparam int SI = stage_secondary(k);
    cse_tap_stage #(.W(W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .adv      (adv),
      .pri      (term[PI]),
      .sec      (term[SI]),
      .carry_in (link[k+1]),
      .acc_q    (link[k])
    );
  end

  assign y = link[0];
endmodule

// File: rtl/fir_cse_top.sv
module fir_cse_top
  import fir_cse_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = IN_W + GAIN_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int CNT_W = $clog2(TAPS);

  logic                    accept;
  logic                    window_full;
  logic [CNT_W-1:0]        fill_q;
  logic signed [OUT_W-1:0] x_ext;
  logic signed [OUT_W-1:0] x_prev_q;

  logic signed [OUT_W-1:0] sx_a5, sx_b9, sx_c7, sx_s21, sx_s19, sx_pair;
  logic signed [OUT_W-1:0] term [NUM_TERMS];

  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;
  assign window_full = (fill_q == CNT_W'(TAPS - 1));
  assign x_ext       = {{(OUT_W-IN_W){in_data[IN_W-1]}}, in_data};

  // Counts accepts until the delay line holds a full window
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (accept && !window_full) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  // Previous accepted sample for the vertical pair
  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev_q <= '0;
    end else if (accept) begin
      x_prev_q <= x_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= window_full;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  cse_subexpr_bank #(.W(OUT_W)) u_bank (
    .cur     (x_ext),
    .prev    (x_prev_q),
    .sx_a5   (sx_a5),
    .sx_b9   (sx_b9),
    .sx_c7   (sx_c7),
    .sx_s21  (sx_s21),
    .sx_s19  (sx_s19),
    .sx_pair (sx_pair)
  );

  cse_product_net #(.W(OUT_W)) u_net (
    .sx_a5   (sx_a5),
    .sx_b9   (sx_b9),
    .sx_c7   (sx_c7),
    .sx_s21  (sx_s21),
    .sx_s19  (sx_s19),
    .sx_pair (sx_pair),
    .term    (term)
  );

  cse_tap_chain #(.W(OUT_W)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .adv  (accept),
    .term (term),
    .y    (out_data)
  );
endmodule

// File: rtl/fir_cse_checker.sv
module fir_cse_checker
  import fir_cse_pkg::*;
#(
  parameter int OUT_W = 29
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_data
);
  localparam int SEEN_W = $clog2(TAPS + 1);

  logic              acc_c;
  logic [SEEN_W-1:0] seen_q;

  assign acc_c = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
    end else if (acc_c && (seen_q < SEEN_W'(TAPS))) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  // R5
  p_stall_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  p_no_early_valid_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (seen_q >= SEEN_W'(TAPS)));

  // R4
  p_full_accept_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_c && (seen_q >= SEEN_W'(TAPS - 1))) |=> out_valid);

  // R6
  p_idle_no_change_r6: assert property (@(posedge clk) disable iff (rst)
    (!acc_c && !out_ready) |=> ($stable(out_valid) && $stable(out_data)));

  // R7
  p_drain_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind fir_cse_top fir_cse_checker #(.OUT_W(OUT_W)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_fir_cse_top.sv
`timescale 1ns/1ps
module tb_fir_cse_top;
  localparam int IN_W  = 16;
  localparam int OUT_W = IN_W + 13;
  localparam int NT    = 12;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic signed [IN_W-1:0]  in_data = '0;
  logic                    out_valid;
  logic                    out_ready = 1'b0;
  logic signed [OUT_W-1:0] out_data;

  always #5 clk = ~clk;

  fir_cse_top #(.IN_W(IN_W)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  int     errors = 0;
  int     checks = 0;
  bit     done   = 1'b0;
  longint coef [NT];
  longint hist [NT];
  int     n_acc = 0;
  bit     exp_valid = 1'b0;

  // Digit rows from R2, digit 1 first
  int digits [6][12] = '{
    '{0,0,1,0,1,0,0,-1,0,1,0,1},
    '{0,0,1,0,1,0,1,0,0,-1,0,0},
    '{0,0,0,0,1,0,0,0,0,1,0,1},
    '{0,0,0,1,0,1,0,1,0,0,1,0},
    '{0,0,0,1,0,1,0,-1,0,0,1,0},
    '{0,1,0,0,1,0,1,0,0,1,0,0}
  };

  function automatic void build_coefs();
    for (int h = 0; h < 6; h++) begin
      longint v = 0;
      for (int k = 1; k <= 12; k++) v += longint'(digits[h][k-1]) * (longint'(1) <<< (12 - k));
      coef[h]      = v;
      coef[NT-1-h] = v;
    end
  endfunction

  function automatic longint model_y();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += coef[k] * hist[k];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock: drive, let the edge pass, update the model, sample 2 ns after the edge
  task automatic cycle(input bit v, input logic signed [IN_W-1:0] d, input bit r);
    bit acc;
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    acc = v && (!exp_valid || r);
    @(posedge clk);
    if (acc) begin
      for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(d);
      if (n_acc < NT) n_acc++;
    end
    if (acc)    exp_valid = (n_acc >= NT);
    else if (r) exp_valid = 1'b0;
    #2;
  endtask

  task automatic check_out(input string req);
    check(out_valid == exp_valid, req, "out_valid", longint'(out_valid), longint'(exp_valid));
    if (exp_valid)
      check(longint'(out_data) == model_y(), req, "out_data", longint'(out_data), model_y());
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cycle(1'b0, '0, 1'b0);
    cycle(1'b0, '0, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    n_acc = 0;
    exp_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < NT-1; i++) begin
      cycle(1'b1, IN_W'(100 + 7*i), 1'b1);
      check(out_valid == 1'b0, "R4", "out_valid during fill", longint'(out_valid), 0);
    end
    cycle(1'b1, IN_W'(-321), 1'b1);
    check(out_valid == 1'b1, "R4", "out_valid on 12th accept", longint'(out_valid), 1);
    check_out("R4");
  endtask

  task automatic t_impulse();
    do_reset();
    for (int i = 0; i < NT-1; i++) cycle(1'b1, '0, 1'b1);
    cycle(1'b1, IN_W'(1), 1'b1);
    check(longint'(out_data) == coef[0], "R2", "impulse tap 0", longint'(out_data), coef[0]);
    for (int i = 1; i < NT; i++) begin
      cycle(1'b1, '0, 1'b1);
      check(out_valid && longint'(out_data) == coef[i], "R2", $sformatf("impulse tap %0d", i),
            longint'(out_data), coef[i]);
    end
  endtask

  task automatic t_random_and_extremes();
    do_reset();
    for (int i = 0; i < 60; i++) begin
      cycle(1'b1, IN_W'($urandom), 1'b1);
      if (i >= NT-1) check_out("R3");
    end
    for (int i = 0; i < NT; i++) begin
      cycle(1'b1, 16'sh7fff, 1'b1);
      check_out("R3");
    end
    for (int i = 0; i < NT; i++) begin
      cycle(1'b1, 16'sh8000, 1'b1);
      check_out("R3");
    end
    for (int i = 0; i < NT; i++) begin
      cycle(1'b1, (i % 2 == 0) ? 16'sh7fff : 16'sh8000, 1'b1);
      check_out("R3");
    end
  endtask

  task automatic t_backpressure();
    logic signed [OUT_W-1:0] held;
    do_reset();
    for (int i = 0; i < NT; i++) cycle(1'b1, IN_W'($urandom), 1'b1);
    cycle(1'b1, IN_W'(1234), 1'b0);
    check_out("R5");
    held = out_data;
    for (int i = 0; i < 4; i++) begin
      cycle(1'b1, IN_W'(-9000 + 777*i), 1'b0);
      check(in_ready == 1'b0, "R5", "in_ready while stalled", longint'(in_ready), 0);
      check(out_valid && out_data == held, "R5", "held out_data", longint'(out_data), longint'(held));
    end
    for (int i = 0; i < 6; i++) begin
      cycle(1'b1, IN_W'($urandom), 1'b1);
      check_out("R5");
    end
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 80; i++) begin
      bit v;
      v = ($urandom % 2) == 0;
      cycle(v, IN_W'($urandom), ($urandom % 4) != 0);
      check_out("R6");
    end
  endtask

  task automatic t_drain();
    do_reset();
    for (int i = 0; i < NT; i++) cycle(1'b1, IN_W'($urandom), 1'b1);
    check(out_valid == 1'b1, "R7", "valid before drain", longint'(out_valid), 1);
    cycle(1'b0, '0, 1'b1);
    check(out_valid == 1'b0, "R7", "valid after drain", longint'(out_valid), 0);
    for (int i = 0; i < 5; i++) begin
      cycle(1'b1, IN_W'($urandom), 1'b1);
      check(out_valid == 1'b1, "R7", "one result per cycle", longint'(out_valid), 1);
      check_out("R7");
    end
  endtask

  task automatic t_mid_reset();
    do_reset();
    for (int i = 0; i < 20; i++) cycle(1'b1, IN_W'(20000 - 1500*i), 1'b1);
    do_reset();
    check(out_valid == 1'b0, "R1", "valid after mid-stream reset", longint'(out_valid), 0);
    for (int i = 0; i < NT-1; i++) cycle(1'b1, IN_W'(-500 + 91*i), 1'b1);
    check(out_valid == 1'b0, "R1", "no valid before refill", longint'(out_valid), 0);
    cycle(1'b1, IN_W'(4321), 1'b1);
    check_out("R1");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    build_coefs();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    t_reset_state();
    t_fill();
    t_impulse();
    t_random_and_extremes();
    t_backpressure();
    t_gaps();
    t_drain();
    t_mid_reset();
    finish_run();
  end
endmodule